// File: doc/BRIEF.md
# SD Card Clock Generator with Dual Gating

This block makes the clock that drives an SD card from the host clock. Software picks a power-of-two division ratio through an 8-bit field in which one bit is set, and turns the card clock on with an enable bit in the same 16-bit control register. A second register gives a separate global gate for the card clock. The clock runs only while both the enable bit and the gate are set. To start the clock, software sets the enable bit and then opens the gate. To stop it, software closes the gate and then clears the enable bit.

Every change of ratio or gating is applied only at the end of a low phase of the card clock. A high pulse therefore always lasts its full half-period, and a stopped clock always rests low. The block also gives a one-host-cycle strobe at each card-clock rising edge, which the command and data shifters next to it use.

Top module: `sd_card_clkgen`

## Requirements
- R1: After reset the card clock is low, the rise strobe is low, the control register reads 0x0080 and the gate register reads 0x0000.
- R2: The control register sits at byte address 0x024. Bits 7:0 hold the divider field and bit 8 holds the enable. It reads back what was written, with all other bits reading zero. A write to any address other than the two register addresses changes neither register.
- R3: The gate register sits at byte address 0x138. Only bit 8 is stored, and all other bits read zero.
- R4: When the highest set bit of the divider field is bit k, the card clock period is 2^(k+2) host cycles, with high and low phases of 2^(k+1) cycles each. So 0x80 divides by 512 and 0x01 divides by 4.
- R5: A divider field of 0x00 divides by 2: one host cycle high and one host cycle low.
- R6: A field with several bits set behaves exactly like the field that holds only its highest set bit.
- R7: The card clock toggles only while both the enable bit and the gate bit are 1. Clearing either one stops it, and with the gate closed, setting the enable bit alone never starts it.
- R8: A high phase in progress when the clock is stopped runs to its full length. The clock then stays low and no further rise strobe appears.
- R9: A divider change is applied at the end of a low phase. The high phase in progress and the low phase after it keep the old length, and the next high phase uses the new length.
- R10: When a stopped clock is started by opening the gate, the first rising edge comes H+1 host edges after the edge that writes the gate, where H is the new half-period.
- R11: The rise strobe is high for exactly the one host cycle in which the card clock has just gone high, and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 9 | Byte address of the register access |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| cardClk | output | 1 | Card clock output (registered) |
| cardClkRise | output | 1 | One-cycle strobe on each card-clock rising edge |

## Verification
If the phase counter or the latched setting is wrong, it shows up as a wrong high or low length within one card-clock period. The bench measures each of these lengths in host cycles for every divider bit, for the all-zero field and for several fields with more than one bit set. If the enable or gate state is wrong, the clock either keeps rising after a stop or never starts. The bench watches for this within a fixed window of host cycles. If the settings are loaded at the wrong moment, the high pulse that is running when the ratio changes gets cut short, or the first edge after a start arrives early. Both of these are measured to the exact cycle.

// File: rtl/sd_clkgen_pkg.sv
`timescale 1ns/1ps
package sd_clkgen_pkg;

  // Strobes from the phase control to the divider datapath.
  typedef struct packed {
    logic load;   // latch requested ratio and run state, clear counter
    logic rise;   // drive card clock high, clear counter
    logic fall;   // drive card clock low, clear counter
    logic count;  // advance phase counter
  } clkStrobes_t;

endpackage

// File: rtl/sd_clkgen_regs.sv
`timescale 1ns/1ps
module sd_clkgen_regs #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 9,
  parameter int DIV_BITS  = 8,
  parameter int EN_BIT    = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 9'h024,
  parameter logic [ADDR_W-1:0] GATE_ADDR = 9'h138
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [DIV_BITS-1:0] divField,
  output logic                reqRun
);

  localparam logic [DIV_BITS-1:0] DIV_RESET = DIV_BITS'(1) << (DIV_BITS - 1);

  logic [DIV_BITS-1:0] divReg;
  logic                enReg;
  logic                gateReg;
  logic                ctlHit;
  logic                gateHit;

  assign ctlHit  = regWrEn && (regAddr == CTL_ADDR);
  assign gateHit = regWrEn && (regAddr == GATE_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg  <= DIV_RESET;
      enReg   <= 1'b0;
      gateReg <= 1'b0;
    end else begin
      if (ctlHit) begin
        divReg <= regWrData[DIV_BITS-1:0];
        enReg  <= regWrData[EN_BIT];
      end
      if (gateHit) begin
        gateReg <= regWrData[EN_BIT];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == CTL_ADDR) begin
      regRdData[DIV_BITS-1:0] = divReg;
      regRdData[EN_BIT]       = enReg;
    end else if (regAddr == GATE_ADDR) begin
      regRdData[EN_BIT] = gateReg;
    end
  end

  assign divField = divReg;
  assign reqRun   = enReg && gateReg;

  // R2: control register keeps its value unless written at its own address
  a_r2_ctl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctlHit |=> $stable(divReg) && $stable(enReg));

  // R3: gate register keeps its value unless written at its own address
  a_r3_gate_hold: assert property (@(posedge clk) disable iff (!rstN)
    !gateHit |=> $stable(gateReg));

endmodule

// File: rtl/sd_clkgen_ctrl.sv
`timescale 1ns/1ps
module sd_clkgen_ctrl
  import sd_clkgen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cardClk,
  input  logic        tc,
  input  logic        activeRun,
  input  logic        reqRun,
  output clkStrobes_t stb
);

  logic lowEnd;

  // A low phase ends at terminal count, or at once while parked.
  assign lowEnd = tc || !activeRun;

  always_comb begin
    stb = '0;
    if (cardClk) begin
      if (tc) stb.fall  = 1'b1;
      else    stb.count = 1'b1;
    end else begin
      if (lowEnd) begin
        stb.load = 1'b1;
        stb.rise = activeRun && tc && reqRun;
      end else begin
        stb.count = 1'b1;
      end
    end
  end

  // R4: counter, edge and reload actions never collide inappropriately
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rise, stb.fall, stb.count}) && !(stb.load && stb.count));

  // R8: a high phase is never interrupted by a reload
  a_r8_no_load_high: assert property (@(posedge clk) disable iff (!rstN)
    cardClk |-> !stb.load);

endmodule

// File: rtl/sd_clkgen_datapath.sv
`timescale 1ns/1ps
module sd_clkgen_datapath
  import sd_clkgen_pkg::*;
#(
  parameter int DIV_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  clkStrobes_t         stb,
  input  logic [DIV_BITS-1:0] divField,
  input  logic                reqRun,
  output logic                cardClk,
  output logic                riseStb,
  output logic                tc,
  output logic                activeRun
);

  localparam int CODE_W = $clog2(DIV_BITS + 1);
  localparam int CNT_W  = DIV_BITS;
  localparam logic [CODE_W-1:0] CODE_RESET = CODE_W'(DIV_BITS);

  logic [CODE_W-1:0] reqCode;
  logic [CODE_W-1:0] activeCode;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W:0]    halfLen;
  logic [CNT_W-1:0]  halfLast;

  // Highest set bit wins; an empty field gives code 0 (half-period 1).
  always_comb begin
    reqCode = '0;
    for (int i = 0; i < DIV_BITS; i++) begin
      if (divField[i]) reqCode = CODE_W'(i + 1);
    end
  end

  assign halfLen  = (CNT_W+1)'(1) << activeCode;
  assign halfLast = CNT_W'(halfLen - (CNT_W+1)'(1));
  assign tc       = (cnt == halfLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      activeCode <= CODE_RESET;
      activeRun  <= 1'b0;
      cardClk    <= 1'b0;
      riseStb    <= 1'b0;
    end else begin
      if (stb.load || stb.rise || stb.fall) cnt <= '0;
      else if (stb.count)                   cnt <= cnt + CNT_W'(1);
      if (stb.load) begin
        activeCode <= reqCode;
        activeRun  <= reqRun;
      end
      if (stb.rise)      cardClk <= 1'b1;
      else if (stb.fall) cardClk <= 1'b0;
      riseStb <= stb.rise;
    end
  end

  // R4: phase counter never passes the active half-period
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= halfLast);

  // R9: the setting in force cannot change inside a high phase
  a_r9_cfg_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    cardClk && $past(cardClk) |-> $stable(activeCode));

  // R11: strobe only in the first high cycle
  a_r11_stb_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |-> cardClk && !$past(cardClk));

  // R11: every rising edge carries the strobe
  a_r11_rise_has_stb: assert property (@(posedge clk) disable iff (!rstN)
    cardClk && !$past(cardClk) |-> riseStb);

endmodule

// File: rtl/sd_card_clkgen.sv
`timescale 1ns/1ps
module sd_card_clkgen
  import sd_clkgen_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 9,
  parameter int DIV_BITS = 8,
  parameter int EN_BIT   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 9'h024,
  parameter logic [ADDR_W-1:0] GATE_ADDR = 9'h138
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              cardClk,
  output logic              cardClkRise
);

  logic [DIV_BITS-1:0] divField;
  logic                reqRun;
  logic                tc;
  logic                activeRun;
  clkStrobes_t         stb;

  sd_clkgen_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_BITS(DIV_BITS), .EN_BIT(EN_BIT),
    .CTL_ADDR(CTL_ADDR), .GATE_ADDR(GATE_ADDR)
  ) u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .divField(divField), .reqRun(reqRun)
  );

  sd_clkgen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cardClk(cardClk), .tc(tc),
    .activeRun(activeRun), .reqRun(reqRun), .stb(stb)
  );

  sd_clkgen_datapath #(.DIV_BITS(DIV_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .divField(divField), .reqRun(reqRun),
    .cardClk(cardClk), .riseStb(cardClkRise), .tc(tc), .activeRun(activeRun)
  );

  // R7: a rising edge needs both gates open in the cycle before it
  a_r7_rise_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardClk) |-> $past(reqRun));

  // R8: a stopped clock resting low stays low
  a_r8_stay_low: assert property (@(posedge clk) disable iff (!rstN)
    !reqRun && !cardClk |=> !cardClk);

endmodule

// File: tb/sd_card_clkgen_bench.sv
`timescale 1ns/1ps
module sd_card_clkgen_bench;

  localparam logic [8:0] CTL  = 9'h024;
  localparam logic [8:0] GATE = 9'h138;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [8:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        cardClk;
  logic        cardClkRise;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  sd_card_clkgen u_sd_card_clkgen (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .cardClk(cardClk), .cardClkRise(cardClkRise)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at a negedge, commit at the next posedge, release at the negedge after.
  task automatic regWrite(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [8:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic int expHalf(input logic [7:0] f);
    int h = 1;
    for (int i = 0; i < 8; i++) if (f[i]) h = 2 << i;
    return h;
  endfunction

  task automatic waitRise(input int limit, output bit found);
    logic prev = cardClk;
    found = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (!prev && cardClk) begin found = 1'b1; break; end
      prev = cardClk;
    end
  endtask

  // Measures one high and one low phase starting at the next rise.
  task automatic measure(input int exp, input string req);
    bit found;
    int hi, lo, stray;
    bit stbAtRise;
    waitRise(2000, found);
    check(found, req, found, 1);
    stbAtRise = cardClkRise;
    hi = 1; stray = 0;
    forever begin
      @(negedge clk);
      if (!cardClk) break;
      hi++; if (cardClkRise) stray++;
    end
    lo = 1;
    forever begin
      @(negedge clk);
      if (cardClk) break;
      lo++; if (cardClkRise) stray++;
    end
    check(hi == exp, {req, " high"}, hi, exp);
    check(lo == exp, {req, " low"}, lo, exp);
    check(stbAtRise && stray == 0 && cardClkRise, "R11 strobe", stray, 0);
  endtask

  task automatic noRise(input int cycles, input string req);
    int rises = 0;
    int stbs = 0;
    logic prev = cardClk;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!prev && cardClk) rises++;
      if (cardClkRise) stbs++;
      prev = cardClk;
    end
    check(rises == 0 && stbs == 0 && !cardClk, req, rises + stbs, 0);
  endtask

  // Cycles from the write edge to the first high sample.
  task automatic startLatency(input int exp, input string req);
    int k = 0;
    regWrite(GATE, 16'h0100);
    for (int i = 1; i < 1100; i++) begin
      @(negedge clk);
      if (cardClk) begin k = i; break; end
    end
    check(k == exp, req, k, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [7:0] multi [3];
    int hi, lo;
    bit found;
    multi[0] = 8'h03; multi[1] = 8'h55; multi[2] = 8'hFF;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!cardClk && !cardClkRise, "R1 outputs", cardClk, 0);
    regRead(CTL, rd);  check(rd == 16'h0080, "R1 ctl reset", rd, 16'h0080);
    regRead(GATE, rd); check(rd == 16'h0000, "R1 gate reset", rd, 0);

    // R2 / R3: decode and readback
    regWrite(CTL, 16'hFEA5);
    regRead(CTL, rd);  check(rd == 16'h00A5, "R2 ctl readback", rd, 16'h00A5);
    regWrite(9'h026, 16'h01FF);
    regWrite(9'h0E0, 16'h0100);
    regRead(CTL, rd);  check(rd == 16'h00A5, "R2 other addr ignored", rd, 16'h00A5);
    regRead(GATE, rd); check(rd == 16'h0000, "R2 gate untouched", rd, 0);
    regWrite(GATE, 16'hFEFF);
    regRead(GATE, rd); check(rd == 16'h0000, "R3 only bit8", rd, 0);
    regWrite(GATE, 16'hFFFF);
    regRead(GATE, rd); check(rd == 16'h0100, "R3 gate readback", rd, 16'h0100);
    regWrite(GATE, 16'h0000);

    // R7: enable alone never starts the clock
    regWrite(CTL, 16'h0101);
    noRise(64, "R7 gate closed");

    // R10: start from parked, field 0x01 -> H=2
    startLatency(3, "R10 start H2");
    regWrite(GATE, 16'h0000);
    noRise(40, "R8 stopped via gate");
    regWrite(CTL, 16'h0100);
    startLatency(2, "R10 start H1");
    regWrite(GATE, 16'h0000);
    regWrite(CTL, 16'h0104);
    repeat (20) @(negedge clk);
    startLatency(9, "R10 start H8");

    // R4 / R5: sweep all single-bit fields and the empty field
    for (int k = -1; k < 8; k++) begin
      logic [7:0] f = (k < 0) ? 8'h00 : (8'h01 << k);
      regWrite(CTL, {8'h01, f});
      waitRise(2000, found); waitRise(2000, found);
      measure(expHalf(f), (k < 0) ? "R5 div2" : "R4 ratio");
    end

    // R6: multi-bit fields
    for (int m = 0; m < 3; m++) begin
      regWrite(CTL, {8'h01, multi[m]});
      waitRise(2000, found); waitRise(2000, found);
      measure(expHalf(multi[m]), "R6 highest bit");
    end

    // R9: change /512 -> /2 inside a high phase
    regWrite(CTL, 16'h0180);
    waitRise(2000, found); waitRise(2000, found);
    hi = 1;
    forever begin
      @(negedge clk);
      if (hi == 10) begin regWrEn = 1'b1; regAddr = CTL; regWrData = 16'h0100; end
      else regWrEn = 1'b0;
      if (!cardClk) break;
      hi++;
    end
    regWrEn = 1'b0;
    lo = 1;
    forever begin @(negedge clk); if (cardClk) break; lo++; end
    check(hi == 256, "R9 old high kept", hi, 256);
    check(lo == 256, "R9 old low kept", lo, 256);
    @(negedge clk);
    check(!cardClk, "R9 new high length", cardClk, 0);
    @(negedge clk);
    check(cardClk, "R9 new low length", cardClk, 1);

    // R8: stop during a high phase with H=2
    regWrite(CTL, 16'h0101);
    waitRise(2000, found); waitRise(2000, found);
    regWrEn = 1'b1; regAddr = GATE; regWrData = 16'h0000;
    hi = 1;
    forever begin
      @(negedge clk);
      regWrEn = 1'b0;
      if (!cardClk) break;
      hi++;
    end
    check(hi == 2, "R8 high completes", hi, 2);
    noRise(64, "R8 parks low");

    // R7: stop via enable bit with gate open
    regWrite(GATE, 16'h0100);
    regWrite(CTL, 16'h0102);
    measure(4, "R7 running");
    regWrite(CTL, 16'h0002);
    repeat (20) @(negedge clk);
    noRise(64, "R7 enable cleared");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule